// File: doc/BRIEF.md
# Adaptive Fetch Thread Selector

This block decides, every cycle, which hardware thread of a simultaneous multithreading front end owns the instruction fetch slot. For every thread it keeps three occupancy counters. The first holds the instructions sitting in the decode, rename and issue-queue stages. The second holds the branches in those same stages. The third holds outstanding data-cache misses. The pipeline keeps each counter current by pulsing an enter strobe when an item arrives and a leave strobe when it departs.

A two-bit mode input chooses the ranking policy. In the rotating policy every thread has equal weight. In each of the three count policies, the thread whose chosen counter is smallest wins. Count ties are broken in rotating order, starting just after the thread picked most recently. Threads flagged in the stall mask cannot be picked. The result is a thread number and a valid flag. Both depend combinationally on the current counters, mask and mode. Counter and rotation-pointer updates take effect at the next clock edge.

Top module: `fetch_thread_selector`

## Requirements
- R1: The mode input selects the ranking key: 0 = rotating (all keys equal), 1 = in-flight instruction count, 2 = in-flight branch count, 3 = outstanding miss count.
- R2: A counter rises by one after a cycle with only its enter strobe high, falls by one after a cycle with only its leave strobe high, and is unchanged when both or neither are high.
- R3: A counter at its maximum (2^CNT_W-1, default 63) stays there on further enter-only strobes.
- R4: A counter at zero stays at zero on further leave-only strobes.
- R5: In a count mode, the selected thread has the lowest value of that mode's counter among the unstalled threads.
- R6: Among unstalled threads sharing the lowest key, the winner is the first one met when scanning upward (with wrap) from the thread after the last selected one.
- R7: In rotating mode, the winner is the first unstalled thread after the last selected one, in increasing order with wrap.
- R8: A thread whose stall_mask bit is 1 is never reported with fetch_valid high.
- R9: When all stall_mask bits are 1, fetch_valid is 0 and the rotation pointer keeps its value. Otherwise fetch_valid is 1.
- R10: Synchronous active-high reset clears all counters and sets the pointer so that thread 0 is first in rotating order.
- R11: The output reflects the counters, mask and mode of the current cycle. A strobe affects the choice from the following cycle on. The pointer takes the value of fetch_tid at each clock edge where fetch_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Ranking policy select |
| insn_enter | input | NUM_THREADS | Per-thread instruction arrival strobes |
| insn_leave | input | NUM_THREADS | Per-thread instruction departure strobes |
| br_enter | input | NUM_THREADS | Per-thread branch arrival strobes |
| br_leave | input | NUM_THREADS | Per-thread branch departure strobes |
| miss_enter | input | NUM_THREADS | Per-thread miss start strobes |
| miss_leave | input | NUM_THREADS | Per-thread miss completion strobes |
| stall_mask | input | NUM_THREADS | 1 = thread may not be chosen |
| fetch_tid | output | $clog2(NUM_THREADS) | Chosen thread number |
| fetch_valid | output | 1 | A thread was chosen |

## Verification
A counter that drifts from the true occupancy shows up only when its mode is active and the drifted value changes a comparison. The bench therefore drives counters to known gaps, to saturation and to below zero, and then lets the affected threads compete. A pointer that is wrong changes the tie winner in the very next cycle, and every cycle is compared against a behavioural model. Counter errors may stay hidden until the next mode switch, so the random phase switches modes often.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    typedef enum logic [1:0] {
        MODE_ROTATE = 2'd0,
        MODE_INSN   = 2'd1,
        MODE_BRANCH = 2'd2,
        MODE_MISS   = 2'd3
    } fetch_mode_e;

    localparam int NUM_EVT = 3;
    localparam int EVT_INSN = 0;
    localparam int EVT_BRANCH = 1;
    localparam int EVT_MISS = 2;
endpackage

// File: rtl/fsel_occ_counter.sv
module fsel_occ_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up,
    input  logic             down,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (up && !down && count != CNT_MAX) begin
            count <= count + 1'b1;
        end else if (down && !up && count != '0) begin
            count <= count - 1'b1;
        end
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX && up && !down) |=> count == CNT_MAX); // R3
    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && down && !up) |=> count == '0); // R4
    AST_CNT_BOTH: assert property (@(posedge clk) disable iff (rst)
        (up && down) |=> $stable(count)); // R2
endmodule

// File: rtl/fsel_occ_bank.sv
module fsel_occ_bank
    import fsel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W = 6
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [NUM_EVT-1:0][NUM_THREADS-1:0]       enter,
    input  logic [NUM_EVT-1:0][NUM_THREADS-1:0]       leave,
    output logic [NUM_EVT-1:0][NUM_THREADS-1:0][CNT_W-1:0] counts
);
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
            fsel_occ_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .up    (enter[e][t]),
                .down  (leave[e][t]),
                .count (counts[e][t])
            );
        end
    end
endmodule

// File: rtl/fsel_pick.sv
module fsel_pick #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W = 6,
    localparam int TID_W = $clog2(NUM_THREADS)
) (
    input  logic [NUM_THREADS-1:0][CNT_W-1:0] key,
    input  logic [NUM_THREADS-1:0]            mask,
    input  logic [TID_W-1:0]                  last,
    output logic [TID_W-1:0]                  tid,
    output logic                              valid
);
    always_comb begin
        logic [CNT_W-1:0] best;
        valid = 1'b0;
        best  = '0;
        tid   = '0;
        for (int k = 1; k <= NUM_THREADS; k++) begin
            int idx;
            idx = (int'(last) + k) % NUM_THREADS;
            if (!mask[idx] && (!valid || key[idx] < best)) begin
                valid = 1'b1;
                best  = key[idx];
                tid   = TID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/fetch_thread_selector.sv
module fetch_thread_selector
    import fsel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W = 6,
    localparam int TID_W = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             mode,
    input  logic [NUM_THREADS-1:0] insn_enter,
    input  logic [NUM_THREADS-1:0] insn_leave,
    input  logic [NUM_THREADS-1:0] br_enter,
    input  logic [NUM_THREADS-1:0] br_leave,
    input  logic [NUM_THREADS-1:0] miss_enter,
    input  logic [NUM_THREADS-1:0] miss_leave,
    input  logic [NUM_THREADS-1:0] stall_mask,
    output logic [TID_W-1:0]       fetch_tid,
    output logic                   fetch_valid
);
    localparam logic [TID_W-1:0] LAST_INIT = TID_W'(NUM_THREADS - 1);

    logic [NUM_EVT-1:0][NUM_THREADS-1:0]            ev_enter;
    logic [NUM_EVT-1:0][NUM_THREADS-1:0]            ev_leave;
    logic [NUM_EVT-1:0][NUM_THREADS-1:0][CNT_W-1:0] counts;
    logic [NUM_THREADS-1:0][CNT_W-1:0]              key;
    logic [TID_W-1:0]                               last_q;
    fetch_mode_e                                    mode_e;

    assign mode_e = fetch_mode_e'(mode);

    always_comb begin
        ev_enter[EVT_INSN]   = insn_enter;
        ev_enter[EVT_BRANCH] = br_enter;
        ev_enter[EVT_MISS]   = miss_enter;
        ev_leave[EVT_INSN]   = insn_leave;
        ev_leave[EVT_BRANCH] = br_leave;
        ev_leave[EVT_MISS]   = miss_leave;
    end

    fsel_occ_bank #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .enter  (ev_enter),
        .leave  (ev_leave),
        .counts (counts)
    );

    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            unique case (mode_e)
                MODE_INSN:   key[t] = counts[EVT_INSN][t];
                MODE_BRANCH: key[t] = counts[EVT_BRANCH][t];
                MODE_MISS:   key[t] = counts[EVT_MISS][t];
                default:     key[t] = '0;
            endcase
        end
    end

    fsel_pick #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_pick (
        .key   (key),
        .mask  (stall_mask),
        .last  (last_q),
        .tid   (fetch_tid),
        .valid (fetch_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= LAST_INIT;
        end else if (fetch_valid) begin
            last_q <= fetch_tid;
        end
    end

    AST_MASKED_SKIP: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> !stall_mask[fetch_tid]); // R8
    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (&stall_mask) |-> !fetch_valid); // R9
    AST_ANY_OPEN: assert property (@(posedge clk) disable iff (rst)
        !(&stall_mask) |-> fetch_valid); // R9
    AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_ROTATE && stall_mask == '0 && !$past(rst)
         && $past(fetch_valid))
        |-> fetch_tid == TID_W'((int'($past(fetch_tid)) + 1) % NUM_THREADS)); // R7
endmodule

// File: tb/test_fetch_thread_selector.sv
module test_fetch_thread_selector;
    localparam int NT = 4;
    localparam int CW = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic [NT-1:0] insn_enter = '0, insn_leave = '0;
    logic [NT-1:0] br_enter = '0, br_leave = '0;
    logic [NT-1:0] miss_enter = '0, miss_leave = '0;
    logic [NT-1:0] stall_mask = '0;
    logic [1:0]    fetch_tid;
    logic          fetch_valid;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    string req = "R10";

    int m_cnt[3][NT];
    int m_last;

    always #10 clk = ~clk;

    fetch_thread_selector #(.NUM_THREADS(NT), .CNT_W(CW)) i_fetch_thread_selector (
        .clk(clk), .rst(rst), .mode(mode),
        .insn_enter(insn_enter), .insn_leave(insn_leave),
        .br_enter(br_enter), .br_leave(br_leave),
        .miss_enter(miss_enter), .miss_leave(miss_leave),
        .stall_mask(stall_mask),
        .fetch_tid(fetch_tid), .fetch_valid(fetch_valid)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected <=100000", cycles);
            finish_run();
        end
    end

    function automatic int key_of(int t);
        if (mode == 2'd0) return 0;
        return m_cnt[int'(mode) - 1][t];
    endfunction

    // model choice: lowest key overall, then first in rotating order
    task automatic model_pick(output bit v, output int id);
        int lowest;
        lowest = -1;
        for (int t = 0; t < NT; t++)
            if (!stall_mask[t] && (lowest < 0 || key_of(t) < lowest)) lowest = key_of(t);
        v = (lowest >= 0);
        id = 0;
        if (v) begin
            for (int k = 1; k <= NT; k++) begin
                int c;
                c = (m_last + k) % NT;
                if (!stall_mask[c] && key_of(c) == lowest) begin
                    id = c;
                    break;
                end
            end
        end
    endtask

    function automatic int bump(int v, bit up, bit dn);
        if (up && !dn && v < CMAX) return v + 1;
        if (dn && !up && v > 0) return v - 1;
        return v;
    endfunction

    // compare this cycle, then advance the model as the coming edge will
    task automatic tick();
        bit ev;
        int eid;
        #1;
        model_pick(ev, eid);
        n_checks++;
        if (fetch_valid !== ev || (ev && fetch_tid !== eid[1:0])) begin
            n_fail++;
            $display("FAIL %s: actual valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     req, fetch_valid, fetch_tid, ev, eid);
        end
        for (int t = 0; t < NT; t++) begin
            m_cnt[0][t] = bump(m_cnt[0][t], insn_enter[t], insn_leave[t]);
            m_cnt[1][t] = bump(m_cnt[1][t], br_enter[t], br_leave[t]);
            m_cnt[2][t] = bump(m_cnt[2][t], miss_enter[t], miss_leave[t]);
        end
        if (ev) m_last = eid;
        @(negedge clk);
        insn_enter = '0; insn_leave = '0;
        br_enter = '0; br_leave = '0;
        miss_enter = '0; miss_leave = '0;
    endtask

    initial begin
        for (int e = 0; e < 3; e++)
            for (int t = 0; t < NT; t++) m_cnt[e][t] = 0;
        m_last = NT - 1;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R10: reset state, thread 0 first
        req = "R10";
        tick();

        // R7: plain rotation
        req = "R7";
        repeat (8) tick();

        // R8: stalled threads skipped
        req = "R8";
        stall_mask = 4'b0101;
        repeat (6) tick();
        stall_mask = 4'b1110;
        repeat (3) tick();

        // R9: all stalled, pointer holds
        req = "R9";
        stall_mask = 4'b1111;
        repeat (3) tick();
        stall_mask = 4'b0000;
        repeat (2) tick();

        // R2 / R5: build instruction counts 3,1,2,0 and watch R11 timing
        req = "R2";
        mode = 2'd1;
        for (int i = 0; i < 3; i++) begin
            insn_enter = 4'b0001 | (i < 1 ? 4'b0010 : 4'b0) | (i < 2 ? 4'b0100 : 4'b0);
            tick();
        end
        req = "R5";
        repeat (3) tick();
        req = "R11";
        insn_enter = 4'b1000; tick();
        insn_enter = 4'b1000; tick();
        tick();
        req = "R2";
        insn_enter = 4'b0010; insn_leave = 4'b0010; tick();
        tick();

        // R6: equal counts, ties rotate
        req = "R6";
        mode = 2'd2;
        repeat (6) tick();
        stall_mask = 4'b0010;
        repeat (4) tick();
        stall_mask = 4'b0000;

        // R1: branch and miss keys differ from instruction key
        req = "R1";
        br_enter = 4'b0011; tick();
        miss_enter = 4'b1100; tick();
        repeat (2) tick();
        mode = 2'd3; repeat (3) tick();
        mode = 2'd1; repeat (2) tick();
        mode = 2'd0; repeat (2) tick();

        // R3: saturation of thread 2 instruction count
        req = "R3";
        mode = 2'd1;
        for (int i = 0; i < 70; i++) begin insn_enter = 4'b0100; tick(); end
        for (int i = 0; i < CMAX; i++) begin insn_leave = 4'b0100; tick(); end
        stall_mask = 4'b0011;
        repeat (3) tick();
        stall_mask = 4'b0000;

        // R4: floor at zero for thread 3 miss count
        req = "R4";
        mode = 2'd3;
        for (int i = 0; i < 6; i++) begin miss_leave = 4'b1000; tick(); end
        miss_enter = 4'b1000; tick();
        stall_mask = 4'b0011;
        repeat (3) tick();
        stall_mask = 4'b0000;

        // R5 / R11: random traffic under all modes
        req = "R5";
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 0) mode = 2'($urandom_range(0, 3));
            if (i % 13 == 0) stall_mask = ($urandom_range(0, 9) == 0) ? 4'b1111 : 4'($urandom);
            insn_enter = 4'($urandom); insn_leave = 4'($urandom);
            br_enter = 4'($urandom);   br_leave = 4'($urandom);
            miss_enter = 4'($urandom); miss_leave = 4'($urandom);
            tick();
        end

        finish_run();
    end
endmodule